// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep first-in first-out buffer out of a parameterised number of identical FIFO slices. The slices share the write enable, the write data, the read enable and a common clock. Two rings of tokens decide which slice is active. Only the slice that owns the write token stores incoming words, and only the slice that owns the read token supplies outgoing words. A slice passes its write token to the next slice in the ring when it stores a word into its last physical location. It passes its read token in the same way when it reads its last physical location. Because both tokens travel the ring in the same order, words come out in the order they went in, across slice boundaries.

A per-slice strap picks the slice that starts the ring. After reset, the slice whose strap is low owns both tokens. The block combines the per-slice status into composite empty, full, almost-empty and almost-full outputs. The empty and full outputs follow the current token owners, so they are exact. The almost flags are the conservative combination of all slices, so they are not exact. There is no half-full output, because in a cascade no single slice knows the total occupancy.

The almost-flag thresholds are fixed per slice by parameters. The outputs include the token pulses and the one-hot ownership vectors, so a system can watch the ring.

Top module: `cfifo_cascade`

## Requirements
- R1: While `rst_n` is low and after its release, every slice is empty, `rdata` is 0, `empty` is 1 and `full` is 0. The slice whose bit of `lead_strap_n` is 0 owns both tokens: its bit is the only one set in `w_owner` and in `r_owner`.
- R2: A write is accepted when `wen` is 1 and the write-owner slice holds fewer than SLICE_DEPTH words. The word goes into that slice's next location. When the location written is SLICE_DEPTH-1, that slice's bit of `wtok_pulse` is 1 during the cycle of that write. From the next cycle on, `w_owner` names slice (i+1) mod NUM_SLICES.
- R3: A read is accepted when `ren` is 1 and the read-owner slice holds at least one word. When the location read is SLICE_DEPTH-1, that slice's bit of `rtok_pulse` is 1 during the cycle of that read. From the next cycle on, `r_owner` names slice (i+1) mod NUM_SLICES.
- R4: Words leave in the order they were accepted, across slice boundaries. After the clock edge that accepts a read, `rdata` holds the word read.
- R5: `full` is 1 exactly when the write-owner slice holds SLICE_DEPTH words. A write request while `full` is 1 stores nothing and does not move the token.
- R6: `empty` is 1 exactly when the read-owner slice holds no word. A read request while `empty` is 1 is ignored, and `rdata` keeps the last word read.
- R7: `almost_empty` is 1 exactly when every slice holds AE_LEVEL words or fewer.
- R8: `almost_full` is 1 exactly when every slice holds SLICE_DEPTH-AF_LEVEL words or more.
- R9: A read and a write accepted in the same cycle both take effect, including when the two tokens sit in different slices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| lead_strap_n | input | NUM_SLICES | Per-slice strap; the single 0 bit marks the ring's starting slice |
| wen | input | 1 | Write request |
| wdata | input | DATA_W | Write data |
| ren | input | 1 | Read request |
| rdata | output | DATA_W | Last word read |
| empty | output | 1 | Read-owner slice is empty |
| full | output | 1 | Write-owner slice is full |
| almost_empty | output | 1 | All slices at or below AE_LEVEL words |
| almost_full | output | 1 | All slices at or above SLICE_DEPTH-AF_LEVEL words |
| w_owner | output | NUM_SLICES | One-hot write-token owner |
| r_owner | output | NUM_SLICES | One-hot read-token owner |
| wtok_pulse | output | NUM_SLICES | Write-token hand-off pulse per slice |
| rtok_pulse | output | NUM_SLICES | Read-token hand-off pulse per slice |

## Verification
The bench drives the block across every slice boundary in both directions. A token that moves one location early or late would scramble the word order or show up as a wrong owner vector or a misplaced pulse. It fills the whole ring and keeps writing, then drains it and keeps reading. A design that lets a write past a full owner, or moves a token while blocked, would corrupt the data or change `rdata`. Long runs of mixed, simultaneous traffic keep the two tokens in different slices, so the composite flags are checked with owners that differ. A second reset with a different strap shows that the starting slice comes from the strap and not from a fixed index.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;

    typedef struct packed {
        logic empty;
        logic full;
        logic aempty;
        logic afull;
    } slice_flags_t;

endpackage

// File: rtl/cfifo_slice.sv
module cfifo_slice
    import cfifo_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SLICE_DEPTH = 8,
    parameter int AE_LEVEL    = 2,
    parameter int AF_LEVEL    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_n,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ren,
    input  logic              wtok_in,
    input  logic              rtok_in,
    output logic              wtok_out,
    output logic              rtok_out,
    output logic              w_own,
    output logic              r_own,
    output logic [DATA_W-1:0] head,
    output slice_flags_t      flags
);
    localparam int AW = (SLICE_DEPTH > 1) ? $clog2(SLICE_DEPTH) : 1;
    localparam int CW = $clog2(SLICE_DEPTH + 1);
    localparam logic [AW-1:0] LAST_LOC = AW'(SLICE_DEPTH - 1);
    localparam logic [CW-1:0] CAP      = CW'(SLICE_DEPTH);
    localparam logic [CW-1:0] AE_CNT   = CW'(AE_LEVEL);
    localparam logic [CW-1:0] AF_CNT   = CW'(SLICE_DEPTH - AF_LEVEL);

    typedef struct packed {
        logic          own_w;
        logic          own_r;
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } slice_state_t;

    slice_state_t state_d, state_q;
    logic [DATA_W-1:0] mem_d [SLICE_DEPTH];
    logic [DATA_W-1:0] mem_q [SLICE_DEPTH];
    logic wr_fire, rd_fire;

    always_comb begin
        state_d  = state_q;
        mem_d    = mem_q;
        wr_fire  = state_q.own_w && wen && (state_q.count < CAP);
        rd_fire  = state_q.own_r && ren && (state_q.count != '0);
        wtok_out = wr_fire && (state_q.wptr == LAST_LOC);
        rtok_out = rd_fire && (state_q.rptr == LAST_LOC);
        if (wr_fire) begin
            mem_d[state_q.wptr] = wdata;
            state_d.wptr = wtok_out ? '0 : state_q.wptr + 1'b1;
        end
        if (rd_fire) begin
            state_d.rptr = rtok_out ? '0 : state_q.rptr + 1'b1;
        end
        case ({wr_fire, rd_fire})
            2'b10:   state_d.count = state_q.count + 1'b1;
            2'b01:   state_d.count = state_q.count - 1'b1;
            default: state_d.count = state_q.count;
        endcase
        state_d.own_w = (state_q.own_w && !wtok_out) || wtok_in;
        state_d.own_r = (state_q.own_r && !rtok_out) || rtok_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.own_w <= !lead_n;
            state_q.own_r <= !lead_n;
            state_q.wptr  <= '0;
            state_q.rptr  <= '0;
            state_q.count <= '0;
            for (int i = 0; i < SLICE_DEPTH; i++) mem_q[i] <= '0;
        end else begin
            state_q <= state_d;
            mem_q   <= mem_d;
        end
    end

    assign w_own        = state_q.own_w;
    assign r_own        = state_q.own_r;
    assign head         = mem_q[state_q.rptr];
    assign flags.empty  = (state_q.count == '0);
    assign flags.full   = (state_q.count == CAP);
    assign flags.aempty = (state_q.count <= AE_CNT);
    assign flags.afull  = (state_q.count >= AF_CNT);

    // R5: occupancy never exceeds the slice depth
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.count <= CAP);
    // R2: a slice that hands on its write token no longer owns it
    a_r2_wtok_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wtok_out && !wtok_in) |=> !w_own);
    // R2: a slice that receives the write token owns it next cycle
    a_r2_wtok_take: assert property (@(posedge clk) disable iff (!rst_n)
        wtok_in |=> w_own);
    // R3: read token handed on and received
    a_r3_rtok_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rtok_out && !rtok_in) |=> !r_own);
    a_r3_rtok_take: assert property (@(posedge clk) disable iff (!rst_n)
        rtok_in |=> r_own);
    // R6: an empty slice never reads
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        flags.empty |-> !rtok_out);

endmodule

// File: rtl/cfifo_flag_merge.sv
module cfifo_flag_merge
    import cfifo_pkg::*;
#(
    parameter int NUM_SLICES = 4
) (
    input  logic [NUM_SLICES-1:0] w_own,
    input  logic [NUM_SLICES-1:0] r_own,
    input  slice_flags_t          flags [NUM_SLICES],
    output logic                  empty,
    output logic                  full,
    output logic                  almost_empty,
    output logic                  almost_full
);
    logic [NUM_SLICES-1:0] empty_v, full_v, ae_v, af_v;

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_split
        assign empty_v[g] = flags[g].empty;
        assign full_v[g]  = flags[g].full;
        assign ae_v[g]    = flags[g].aempty;
        assign af_v[g]    = flags[g].afull;
    end

    assign empty        = |(empty_v & r_own);
    assign full         = |(full_v & w_own);
    assign almost_empty = &ae_v;
    assign almost_full  = &af_v;

endmodule

// File: rtl/cfifo_read_sel.sv
module cfifo_read_sel #(
    parameter int NUM_SLICES = 4,
    parameter int DATA_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SLICES-1:0] r_own,
    input  logic [DATA_W-1:0]     heads [NUM_SLICES],
    input  logic                  ren,
    input  logic                  empty,
    output logic [DATA_W-1:0]     rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } out_state_t;

    out_state_t state_d, state_q;
    logic [DATA_W-1:0] picked;

    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_SLICES; i++) begin
            if (r_own[i]) picked = picked | heads[i];
        end
        state_d = state_q;
        if (ren && !empty) state_d.data = picked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rdata = state_q.data;

    // R6: no read leaves the output word unchanged
    a_r6_hold_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> $stable(rdata));

endmodule

// File: rtl/cfifo_cascade.sv
module cfifo_cascade
    import cfifo_pkg::*;
#(
    parameter int NUM_SLICES  = 4,
    parameter int SLICE_DEPTH = 8,
    parameter int DATA_W      = 16,
    parameter int AE_LEVEL    = 2,
    parameter int AF_LEVEL    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SLICES-1:0] lead_strap_n,
    input  logic                  wen,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  ren,
    output logic [DATA_W-1:0]     rdata,
    output logic                  empty,
    output logic                  full,
    output logic                  almost_empty,
    output logic                  almost_full,
    output logic [NUM_SLICES-1:0] w_owner,
    output logic [NUM_SLICES-1:0] r_owner,
    output logic [NUM_SLICES-1:0] wtok_pulse,
    output logic [NUM_SLICES-1:0] rtok_pulse
);
    logic [NUM_SLICES-1:0] wtok_in, rtok_in;
    logic [DATA_W-1:0]     heads [NUM_SLICES];
    slice_flags_t          flags [NUM_SLICES];

    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
        localparam int PREV = (g + NUM_SLICES - 1) % NUM_SLICES;
        assign wtok_in[g] = wtok_pulse[PREV];
        assign rtok_in[g] = rtok_pulse[PREV];

        cfifo_slice #(
            .DATA_W      (DATA_W),
            .SLICE_DEPTH (SLICE_DEPTH),
            .AE_LEVEL    (AE_LEVEL),
            .AF_LEVEL    (AF_LEVEL)
        ) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .lead_n   (lead_strap_n[g]),
            .wen      (wen),
            .wdata    (wdata),
            .ren      (ren),
            .wtok_in  (wtok_in[g]),
            .rtok_in  (rtok_in[g]),
            .wtok_out (wtok_pulse[g]),
            .rtok_out (rtok_pulse[g]),
            .w_own    (w_owner[g]),
            .r_own    (r_owner[g]),
            .head     (heads[g]),
            .flags    (flags[g])
        );
    end

    cfifo_flag_merge #(.NUM_SLICES(NUM_SLICES)) u_merge (
        .w_own        (w_owner),
        .r_own        (r_owner),
        .flags        (flags),
        .empty        (empty),
        .full         (full),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

    cfifo_read_sel #(.NUM_SLICES(NUM_SLICES), .DATA_W(DATA_W)) u_rsel (
        .clk   (clk),
        .rst_n (rst_n),
        .r_own (r_owner),
        .heads (heads),
        .ren   (ren),
        .empty (empty),
        .rdata (rdata)
    );

    // R1: exactly one slice owns each token at all times
    a_r1_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(w_owner) == 1);
    a_r1_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(r_owner) == 1);
    // R5: a blocked write does not pass the write token
    a_r5_full_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (wtok_pulse == '0));

endmodule

// File: tb/cfifo_cascade_bench.sv
module cfifo_cascade_bench;
    localparam int N  = 4;
    localparam int D  = 8;
    localparam int DW = 16;
    localparam int AE = 2;
    localparam int AF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] lead_strap_n = 4'b1110;
    logic wen = 1'b0, ren = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic empty, full, almost_empty, almost_full;
    logic [N-1:0] w_owner, r_owner, wtok_pulse, rtok_pulse;

    always #2 clk = ~clk;

    cfifo_cascade #(.NUM_SLICES(N), .SLICE_DEPTH(D), .DATA_W(DW),
                    .AE_LEVEL(AE), .AF_LEVEL(AF)) u_cfifo_cascade (
        .clk(clk), .rst_n(rst_n), .lead_strap_n(lead_strap_n),
        .wen(wen), .wdata(wdata), .ren(ren), .rdata(rdata),
        .empty(empty), .full(full), .almost_empty(almost_empty),
        .almost_full(almost_full), .w_owner(w_owner), .r_owner(r_owner),
        .wtok_pulse(wtok_pulse), .rtok_pulse(rtok_pulse));

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural model
    logic [DW-1:0] q[$];
    int cnt [N];
    int wpos[N];
    int rpos[N];
    int wo, ro;
    logic [DW-1:0] exp_rdata;
    logic [DW-1:0] next_val;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset(input int lead);
        q.delete();
        for (int i = 0; i < N; i++) begin cnt[i] = 0; wpos[i] = 0; rpos[i] = 0; end
        wo = lead; ro = lead; exp_rdata = '0;
    endtask

    task automatic check_state(input string ph);
        logic ae_e, af_e;
        ae_e = 1'b1; af_e = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (cnt[i] > AE) ae_e = 1'b0;
            if (cnt[i] < D - AF) af_e = 1'b0;
        end
        chk({ph, " R6 empty"}, empty, cnt[ro] == 0);
        chk({ph, " R5 full"}, full, cnt[wo] == D);
        chk({ph, " R7 almost_empty"}, almost_empty, ae_e);
        chk({ph, " R8 almost_full"}, almost_full, af_e);
        chk({ph, " R2 w_owner"}, w_owner, 32'(1 << wo));
        chk({ph, " R3 r_owner"}, r_owner, 32'(1 << ro));
        chk({ph, " R4 rdata"}, rdata, exp_rdata);
    endtask

    task automatic step(input string ph, input logic w, input logic r);
        logic wf, rf;
        logic [N-1:0] wp, rp;
        @(negedge clk);
        check_state(ph);
        wen = w; ren = r; wdata = next_val;
        wf = w && (cnt[wo] < D);
        rf = r && (cnt[ro] > 0);
        wp = '0; rp = '0;
        if (wf && wpos[wo] == D - 1) wp[wo] = 1'b1;
        if (rf && rpos[ro] == D - 1) rp[ro] = 1'b1;
        #1;
        chk({ph, " R2 wtok_pulse"}, wtok_pulse, wp);
        chk({ph, " R3 rtok_pulse"}, rtok_pulse, rp);
        @(posedge clk);
        if (rf) begin
            exp_rdata = q.pop_front();
            cnt[ro]--;
            if (rpos[ro] == D - 1) begin rpos[ro] = 0; ro = (ro + 1) % N; end
            else rpos[ro]++;
        end
        if (wf) begin
            q.push_back(wdata);
            cnt[wo]++;
            if (wpos[wo] == D - 1) begin wpos[wo] = 0; wo = (wo + 1) % N; end
            else wpos[wo]++;
            next_val = next_val + 16'h0101;
        end
    endtask

    task automatic do_reset(input logic [N-1:0] strap, input int lead);
        @(negedge clk);
        rst_n = 1'b0; wen = 1'b0; ren = 1'b0; lead_strap_n = strap;
        model_reset(lead);
        repeat (2) @(negedge clk);
        // R1: state while reset is held
        chk("R1 reset empty", empty, 1'b1);
        chk("R1 reset full", full, 1'b0);
        chk("R1 reset rdata", rdata, '0);
        chk("R1 reset w_owner", w_owner, 32'(1 << lead));
        chk("R1 reset r_owner", r_owner, 32'(1 << lead));
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        next_val = 16'h1001;
        do_reset(4'b1110, 0);
        step("R1 after reset", 0, 0);
        for (int i = 0; i < 10; i++) step("R2 write cross", 1, 0);
        for (int i = 0; i < 10; i++) step("R3 read cross", 0, 1);
        for (int i = 0; i < 35; i++) step("R5 fill", 1, 0);
        for (int i = 0; i < 36; i++) step("R6 drain", 0, 1);
        for (int i = 0; i < 600; i++) begin
            int v;
            v = $urandom_range(0, 3);
            step("R9 mixed", (v != 0), (v != 1) && (i > 40 ? 1'b1 : v == 3));
        end
        for (int i = 0; i < 60; i++) step("R9 drain", 0, 1);
        do_reset(4'b1011, 2);
        step("R1 strap two", 0, 0);
        for (int i = 0; i < 20; i++) step("R2 strap two write", 1, 0);
        for (int i = 0; i < 22; i++) step("R4 strap two read", 0, 1);
        step("R6 final", 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule